// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

The block produces one pixel-rate timing output for each display channel. The timing comes from one of several source clocks. All logic runs on a single core clock. Each source clock reaches the block as a one-cycle tick on the core clock, and each tick stands for one source cycle. For every channel the block gives two outputs:

- a level, `pix_clk`, that follows the divided waveform;
- a strobe, `pix_stb`, that pulses in the last core cycle of each output period and serves as a clock enable for the display pipeline.

Software programs each channel through its own control word, written and read back over a small register port. The control word has four fields:

| Field | Bits (default parameters) | Meaning |
|---|---|---|
| divide | [9:0] | ratio minus two |
| bypass | [10] | 1 = pass the source through undivided |
| clock type | [11] | 0 = internal generation, 1 = external pixel clock |
| source select | [13:12] | which source tick input to use |

The divide field is offset-encoded, so the all-zero reset value divides by two. Changes are staged. A written word takes effect only when the current output period ends, so reprogramming never produces a shortened or stretched pulse.

Top module: `pixdiv_top`

## Requirements
- R1: A divide field value N gives an output period of N+2 selected source cycles: one strobe per period, asserted in the cycle that carries the period's last tick.
- R2: Within each period `pix_clk` is high for the first floor(ratio/2) source cycles and low for the rest. This gives exactly half for even ratios.
- R3: When the bypass bit (bit DIV_W) is set, the strobe fires on every selected tick and `pix_clk` stays high, whatever the divide field holds.
- R4: After reset both control words read zero, and each channel divides its source 0 by two.
- R5: With the clock-type bit clear, source select value k (bits DIV_W+2 upward) uses `src_tick[k]`. A value of N_SRC or more selects no source, so no strobe occurs and `pix_clk` holds its value.
- R6: With the clock-type bit (bit DIV_W+1) set, channel c counts `ext_tick[c]` instead of the selected source.
- R7: A write changes only the control word at `wr_addr`. The other channel's readback and output period are unaffected.
- R8: A new control word takes effect only after the output period in progress has completed with the old settings.
- R9: While the active settings select no source, a newly written word becomes active on the following core cycle, without waiting for a period end.
- R10: `rd_data` returns the last word written to `rd_addr`, or zero if that word has not been written since reset.
- R11: The largest divide value 2^DIV_W−1 gives a ratio of 2^DIV_W+1, with a high time of 2^(DIV_W−1) source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | N_SRC | One tick per source clock cycle, one bit per source |
| ext_tick | input | N_CH | External pixel clock ticks, one bit per channel |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | AW | Channel written |
| wr_data | input | CW | Control word to store |
| rd_addr | input | AW | Channel read |
| rd_data | output | CW | Stored control word of channel `rd_addr` |
| pix_clk | output | N_CH | Divided pixel clock level per channel |
| pix_stb | output | N_CH | End-of-period strobe per channel |

## Verification
The divider is driven with ticks on every core cycle, every second cycle and every third cycle. This separates counting of source ticks from counting of core cycles, and tells the internal sources apart from the external input. Even, odd, minimum and maximum ratios are each measured over whole periods, in both length and high time, so an error in the offset encoding or in the duty split shows up as a mismatch. A write issued in mid-period checks that the old period finishes unchanged. A source select value with no source behind it checks both the frozen output and the immediate recovery.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;

   typedef enum logic {
      CK_INTERNAL = 1'b0,
      CK_EXTERNAL = 1'b1
   } ck_type_e;

   // Bit positions inside a control word, given the divide field width.
   function automatic int byp_bit(input int div_w);
      return div_w;
   endfunction

   function automatic int type_bit(input int div_w);
      return div_w + 1;
   endfunction

   function automatic int sel_lsb(input int div_w);
      return div_w + 2;
   endfunction

endpackage

// File: rtl/pixdiv_tick_sel.sv
module pixdiv_tick_sel #(
   parameter int N_SRC = 3,
   parameter int SEL_W = 2
) (
   input  logic [N_SRC-1:0] src_tick,
   input  logic             ext_tick,
   input  logic [SEL_W-1:0] sel,
   input  logic             ck_type,
   output logic             tick,
   output logic             tick_ok
);
   import pixdiv_pkg::*;

   logic int_tick;
   logic int_ok;

   always_comb begin
      int_tick = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) int_tick = src_tick[i];
      end
   end

   generate
      if (N_SRC == (1 << SEL_W)) begin : g_full
         assign int_ok = 1'b1;
      end else begin : g_sparse
         assign int_ok = ({1'b0, sel} < (SEL_W+1)'(N_SRC));
      end
   endgenerate

   assign tick    = (ck_type == CK_EXTERNAL) ? ext_tick : int_tick;
   assign tick_ok = (ck_type == CK_EXTERNAL) | int_ok;

endmodule

// File: rtl/pixdiv_chan.sv
module pixdiv_chan #(
   parameter int DIV_W = 10,
   parameter int N_SRC = 3,
   parameter int SEL_W = 2,
   localparam int CW    = DIV_W + 2 + SEL_W,
   localparam int CNT_W = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_tick,
   input  logic             ext_tick,
   input  logic [CW-1:0]    pend_ctrl,
   output logic             pix_clk,
   output logic             pix_stb
);
   import pixdiv_pkg::*;

   localparam int BYP = byp_bit(DIV_W);
   localparam int TYP = type_bit(DIV_W);
   localparam int SEL = sel_lsb(DIV_W);

   logic [CW-1:0]    act_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick, tick_ok, stall, per_end;
   logic [CNT_W-1:0] last_cnt, half_cnt;
   logic             act_byp;

   assign act_byp = act_q[BYP];

   pixdiv_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
      .src_tick (src_tick),
      .ext_tick (ext_tick),
      .sel      (act_q[SEL +: SEL_W]),
      .ck_type  (act_q[TYP]),
      .tick     (tick),
      .tick_ok  (tick_ok)
   );

   assign last_cnt = {1'b0, act_q[DIV_W-1:0]} + CNT_W'(1);
   assign half_cnt = ({1'b0, act_q[DIV_W-1:0]} + CNT_W'(2)) >> 1;
   assign stall    = !tick_ok;
   assign per_end  = tick && (act_byp || (cnt_q == last_cnt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (stall) begin
         act_q <= pend_ctrl;
         cnt_q <= '0;
      end else if (per_end) begin
         act_q <= pend_ctrl;
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign pix_stb = per_end;
   assign pix_clk = act_byp ? 1'b1 : (cnt_q < half_cnt);

   // R1: the counter stays inside the active period
   a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      !act_byp |-> cnt_q <= last_cnt);
   // R3: in bypass every selected tick closes a period
   a_r3_bypass_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (act_byp && tick) |-> pix_stb);
   // R8: active settings move only at a period end or while stalled
   a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_stb && tick_ok) |=> $stable(act_q));
   // R9: a stalled channel picks up the pending word next cycle
   a_r9_stall_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_ok |=> act_q == $past(pend_ctrl));

endmodule

// File: rtl/pixdiv_regs.sv
module pixdiv_regs #(
   parameter int N_CH = 2,
   parameter int CW   = 14,
   localparam int AW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [CW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [CW-1:0]      rd_data,
   output logic [N_CH*CW-1:0] ctrl_flat
);
   logic [CW-1:0] word_q [N_CH];

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)                                 word_q[c] <= '0;
            else if (wr_en && (wr_addr == AW'(c)))      word_q[c] <= wr_data;
         end
         assign ctrl_flat[c*CW +: CW] = word_q[c];

         // R7: a write aimed elsewhere leaves this word alone
         a_r7_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr != AW'(c))) |=> $stable(word_q[c]));
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (rd_addr == AW'(c)) rd_data = word_q[c];
      end
   end

   // R10: the word just written reads back when addressed
   a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (rd_addr == wr_addr)) ##1 $stable(rd_addr) |-> rd_data == $past(wr_data));

endmodule

// File: rtl/pixdiv_top.sv
module pixdiv_top #(
   parameter int N_CH  = 2,
   parameter int DIV_W = 10,
   parameter int N_SRC = 3,
   parameter int SEL_W = 2,
   localparam int CW   = DIV_W + 2 + SEL_W,
   localparam int AW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_tick,
   input  logic [N_CH-1:0]  ext_tick,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [CW-1:0]    rd_data,
   output logic [N_CH-1:0]  pix_clk,
   output logic [N_CH-1:0]  pix_stb
);
   generate
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
         $error("pixdiv_top: DIV_W out of range");
      end
      if (N_SRC < 1 || N_SRC > (1 << SEL_W)) begin : g_bad_src
         $error("pixdiv_top: N_SRC does not fit SEL_W");
      end
      if (N_CH < 1) begin : g_bad_ch
         $error("pixdiv_top: N_CH must be positive");
      end
   endgenerate

   logic [N_CH*CW-1:0] ctrl_flat;

   pixdiv_regs #(.N_CH(N_CH), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .ctrl_flat (ctrl_flat)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         pixdiv_chan #(.DIV_W(DIV_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_tick  (src_tick),
            .ext_tick  (ext_tick[c]),
            .pend_ctrl (ctrl_flat[c*CW +: CW]),
            .pix_clk   (pix_clk[c]),
            .pix_stb   (pix_stb[c])
         );
      end
   endgenerate

endmodule

// File: tb/pixdiv_top_bench.sv
module pixdiv_top_bench;

   localparam int N_CH = 2, DIV_W = 10, N_SRC = 3, SEL_W = 2;
   localparam int CW = DIV_W + 2 + SEL_W;

   typedef struct {
      int    len;
      int    hi;
      string tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_SRC-1:0] src_tick = '0;
   logic [N_CH-1:0]  ext_tick = '0;
   logic             wr_en = 1'b0;
   logic [0:0]       wr_addr = '0;
   logic [CW-1:0]    wr_data = '0;
   logic [0:0]       rd_addr = '0;
   logic [CW-1:0]    rd_data;
   logic [N_CH-1:0]  pix_clk, pix_stb;

   int total = 0, bad = 0;
   int cyc = 0;
   int sp[N_SRC];
   int ext_sp[N_CH];
   int stb_cnt[N_CH];
   int len_acc[N_CH];
   int hi_acc[N_CH];
   bit done = 0;
   exp_t qa[$];
   exp_t qb[$];

   pixdiv_top #(.N_CH(N_CH), .DIV_W(DIV_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_pixdiv_top (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_tick(ext_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pix_clk(pix_clk), .pix_stb(pix_stb)
   );

   always #10 clk = ~clk;

   function automatic logic [CW-1:0] mk(int sel, int typ, int byp, int dv);
      return CW'((sel << 12) | (typ << 11) | (byp << 10) | dv);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // tick generation
   always @(negedge clk) begin
      cyc++;
      for (int k = 0; k < N_SRC; k++) src_tick[k] <= (cyc % sp[k] == 0);
      for (int c = 0; c < N_CH; c++)  ext_tick[c] <= (cyc % ext_sp[c] == 0);
   end

   // monitor: measure each period, compare with the queued expectation
   always begin
      @(negedge clk);
      #5;
      for (int c = 0; c < N_CH; c++) begin
         if (!rst_n) begin
            len_acc[c] = 0;
            hi_acc[c]  = 0;
         end else begin
            len_acc[c]++;
            hi_acc[c] += int'(pix_clk[c]);
            if (pix_stb[c]) begin
               exp_t e;
               bit have;
               have = 0;
               if (c == 0 && qa.size() > 0) begin e = qa.pop_front(); have = 1; end
               if (c == 1 && qb.size() > 0) begin e = qb.pop_front(); have = 1; end
               if (have) begin
                  chk(len_acc[c] == e.len, {e.tag, " period length"}, len_acc[c], e.len);
                  chk(hi_acc[c] == e.hi, {e.tag, " high time"}, hi_acc[c], e.hi);
               end
               len_acc[c] = 0;
               hi_acc[c]  = 0;
               stb_cnt[c]++;
            end
         end
      end
   end

   task automatic push(int ch, int n, int len, int hi, string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.len = len; e.hi = hi; e.tag = tag;
         if (ch == 0) qa.push_back(e); else qb.push_back(e);
      end
   endtask

   task automatic wr(int ch, logic [CW-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 1'(ch); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(int ch, logic [CW-1:0] v, int n, int len, int hi, string tag);
      int base;
      wr(ch, v);
      base = stb_cnt[ch];
      wait (stb_cnt[ch] >= base + 2);
      push(ch, n, len, hi, tag);
      base = stb_cnt[ch];
      wait (stb_cnt[ch] >= base + n);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
   end

   initial begin
      int base, lv;
      for (int k = 0; k < N_SRC; k++) sp[k] = 1;
      for (int c = 0; c < N_CH; c++) begin
         ext_sp[c] = 1; stb_cnt[c] = 0; len_acc[c] = 0; hi_acc[c] = 0;
      end
      // R4: first periods out of reset divide source 0 by two
      push(0, 2, 2, 1, "R4");
      push(1, 2, 2, 1, "R4");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      rd_addr = 1'b0; #1;
      chk(rd_data == '0, "R4 reset word A", int'(rd_data), 0);
      rd_addr = 1'b1; #1;
      chk(rd_data == '0, "R10 reset word B", int'(rd_data), 0);
      chk(pix_clk == 2'b11, "R4 reset level", int'(pix_clk), 3);
      wait (stb_cnt[0] >= 2 && stb_cnt[1] >= 2);

      cfg(0, mk(0, 0, 0, 2), 3, 4, 2, "R1");     // even ratio 4
      cfg(0, mk(0, 0, 0, 3), 3, 5, 2, "R2");     // odd ratio 5

      // R8: mid-period rewrite, old period of 5 must finish first
      base = stb_cnt[0];
      wait (stb_cnt[0] >= base + 1);
      push(0, 1, 5, 2, "R8");
      push(0, 2, 7, 3, "R8");
      wr(0, mk(0, 0, 0, 5));
      base = stb_cnt[0];
      wait (stb_cnt[0] >= base + 3);

      cfg(0, mk(0, 0, 1, 7), 4, 1, 1, "R3");     // bypass ignores divide field
      sp[1] = 2;
      cfg(0, mk(1, 0, 0, 1), 3, 6, 2, "R5");     // source 1, ratio 3, tick every 2

      ext_sp[1] = 3;
      cfg(1, mk(0, 1, 0, 0), 3, 6, 3, "R6");     // external ticks every 3
      @(negedge clk); #5;
      rd_addr = 1'b0; #1;
      chk(rd_data == mk(1, 0, 0, 1), "R7 word A after B write", int'(rd_data), int'(mk(1, 0, 0, 1)));
      rd_addr = 1'b1; #1;
      chk(rd_data == mk(0, 1, 0, 0), "R10 word B readback", int'(rd_data), int'(mk(0, 1, 0, 0)));
      push(0, 2, 6, 2, "R7");
      base = stb_cnt[0];
      wait (stb_cnt[0] >= base + 2);

      // R5: select value with no source freezes the channel
      sp[1] = 1;
      wr(0, mk(3, 0, 0, 0));
      base = stb_cnt[0];
      wait (stb_cnt[0] >= base + 1);
      repeat (3) @(negedge clk);
      #5;
      base = stb_cnt[0];
      lv = int'(pix_clk[0]);
      repeat (40) @(negedge clk);
      #5;
      chk(stb_cnt[0] == base, "R5 no strobe without source", stb_cnt[0], base);
      chk(int'(pix_clk[0]) == lv, "R5 level held", int'(pix_clk[0]), lv);
      rd_addr = 1'b0; #1;
      chk(rd_data == mk(3, 0, 0, 0), "R10 word A readback", int'(rd_data), int'(mk(3, 0, 0, 0)));

      // R9: recovery does not wait for a period end
      wr(0, mk(0, 0, 0, 0));
      repeat (3) @(negedge clk);
      #5;
      chk(stb_cnt[0] > base, "R9 immediate reload", stb_cnt[0], base + 1);

      cfg(0, mk(0, 0, 0, 1023), 2, 1025, 512, "R11");

      chk(qa.size() == 0 && qb.size() == 0, "R1 all periods seen", qa.size() + qb.size(), 0);
      summary();
   end

endmodule